// File: doc/BRIEF.md
# FPGA SPI Configuration Sequencer

This block loads a configuration image into an SRAM-based FPGA through the FPGA's serial configuration port, acting as the controller. A pulse on `start_i` launches a fixed sequence. First the active-low configuration reset is pulled low for a set number of microseconds and then released. Next the block waits for the target to clear its configuration memory. It then sends a run of dummy serial clocks with chip select high. The image bytes follow with chip select low. A second run of dummy clocks with chip select high comes after them. Finally the block samples the target's configuration-done line.

The image arrives as bytes on a valid/ready stream, and a flag marks the final byte. Each byte is sent most significant bit first. The serial clock runs in one of two modes. In fast mode each half-period is one system clock. In slow mode each half-period is a programmable count, which allows a square wave of about 1 MHz. Microsecond delays come from a prescaler sized by the system clock frequency in MHz. All delays and clock counts are inputs, so they can be held in any register file around the block.

Top module: `cfg_loader`

## Requirements
- R1: When not busy, including straight after reset, the serial clock is low, chip select is high, configuration reset is high, `s_ready_o` is low and `busy_o` is low.
- R2: A start accepted while idle drives configuration reset low for max(`hold_us_i`,1)×CLK_MHZ system clocks, starting the cycle after the start edge. It is then released and stays released for the rest of the run.
- R3: After release, the block waits max(`wait_us_i`,1)×CLK_MHZ cycles with chip select high and the serial clock low, and only then starts the first low phase of the leading clocks.
- R4: The block issues exactly `lead_clks_i` serial clock pulses with chip select high before the payload. One idle cycle with the clock low follows them before chip select falls.
- R5: Every serial clock pulse is a low phase followed by a high phase of equal length. Each phase is 1 system clock in fast mode (`slow_mode_i`=0) and `half_period_i`+1 system clocks in slow mode.
- R6: During the payload chip select is low and each byte is sent MSB first on `cfg_copi_o`. The data line changes only when the serial clock falls or while it is idle low. It is 0 when no bit is pending.
- R7: `s_ready_o` is high only in the payload phase, while no bits are pending and the final byte has not yet been taken. A byte is taken on a clock edge where `s_valid_i` and `s_ready_o` are both high. Its first bit appears on the next cycle.
- R8: One cycle after the final bit of the byte flagged by `s_last_i`, chip select rises. Exactly `trail_clks_i` serial clock pulses follow with chip select high, then one idle cycle.
- R9: At the end of the run the synchronized `cfg_done_i` is sampled. `done_o` rises if it is high and `error_o` rises if it is low, in the same cycle that `busy_o` falls. The flag stays until the next start clears it. The two flags are never high together.
- R10: `start_i` has no effect while `busy_o` is high.
- R11: A delay of 0 behaves as 1 microsecond. A clock count of 0 yields no dummy clocks and leaves only the single idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a load sequence (accepted only when idle) |
| slow_mode_i | input | 1 | 1 selects the programmable slow serial clock |
| hold_us_i | input | US_W | Configuration reset low time in microseconds |
| wait_us_i | input | US_W | Memory clear wait after release, microseconds |
| lead_clks_i | input | CNT_W | Dummy clocks before the payload |
| trail_clks_i | input | CNT_W | Dummy clocks after the payload |
| half_period_i | input | HALF_W | Slow mode half-period minus one, in system clocks |
| s_data_i | input | BYTE_W | Image byte |
| s_valid_i | input | 1 | Image byte valid |
| s_last_i | input | 1 | Marks the final image byte |
| s_ready_o | output | 1 | Block can take an image byte |
| cfg_rst_no | output | 1 | Active-low configuration reset to the FPGA |
| cfg_cs_no | output | 1 | Active-low chip select to the FPGA |
| cfg_sclk_o | output | 1 | Serial clock to the FPGA |
| cfg_copi_o | output | 1 | Serial data to the FPGA |
| cfg_done_i | input | 1 | Configuration-done from the FPGA |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last run finished with configuration-done high |
| error_o | output | 1 | Last run finished with configuration-done low |

## Verification
Several properties are checked on every cycle:
- idle outputs are quiet;
- chip select and the clock stay inactive while reset is low;
- reset is never pulled low again during a run;
- data holds while the serial clock is high;
- ready appears only with chip select low;
- the flags stay exclusive;
- the prescaler and phase counters stay in range.

Exact durations can only be shown by the bench's scenarios, which compare every output against a reference model on each clock. These durations are the reset and wait times in cycles, the number of leading and trailing pulses, and slow-mode phase lengths. The same scenarios show how the payload behaves when valid arrives with gaps, that bytes go out MSB first, that the done and error outcome is right, and that a start pulse in mid-run is ignored.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

   // Sequence phases of the loader
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RESET,
      ST_CLEAR,
      ST_PRE,
      ST_LOAD,
      ST_POST
   } ld_state_e;

endpackage

// File: rtl/cfg_us_timer.sv
// Microsecond interval timer: a prescaler divides the system clock down to
// 1 us ticks and a tick counter flags when the requested count has elapsed.
module cfg_us_timer #(
   parameter int CLK_MHZ = 50,
   parameter int US_W    = 16
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            en_i,
   input  logic            clr_i,
   input  logic [US_W-1:0] limit_i,
   output logic            expired_o
);
   localparam int PW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
   localparam logic [PW-1:0] PRE_TOP = PW'(CLK_MHZ - 1);

   logic [PW-1:0]   pre_q;
   logic [US_W-1:0] us_q;
   logic            tick;
   logic            final_us;

   assign tick      = en_i && (pre_q == PRE_TOP);
   // a limit of zero is served as one microsecond
   assign final_us  = ((US_W+1)'(us_q) + (US_W+1)'(1)) >= (US_W+1)'(limit_i);
   assign expired_o = tick && final_us;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pre_q <= '0;
         us_q  <= '0;
      end else if (clr_i) begin
         pre_q <= '0;
         us_q  <= '0;
      end else if (en_i) begin
         pre_q <= tick ? '0 : pre_q + 1'b1;
         if (tick) us_q <= final_us ? '0 : us_q + 1'b1;
      end
   end

   AST_PRESCALE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pre_q <= PRE_TOP); // R2

   AST_TIMER_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (pre_q == '0 && us_q == '0)); // R3

endmodule

// File: rtl/cfg_sclk_gen.sv
// Serial clock phase engine: low phase first, then high phase, each lasting
// one system clock (fast) or half_i+1 system clocks (slow).
module cfg_sclk_gen #(
   parameter int HALF_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic              restart_i,
   input  logic              slow_i,
   input  logic [HALF_W-1:0] half_i,
   output logic              sclk_o,
   output logic              fall_o
);
   logic [HALF_W-1:0] ph_q;
   logic [HALF_W-1:0] phase_lim;
   logic              sclk_q;
   logic              phase_end;

   assign phase_lim = slow_i ? half_i : '0;
   assign phase_end = run_i && (ph_q == phase_lim);
   assign fall_o    = phase_end && sclk_q;
   assign sclk_o    = sclk_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q   <= '0;
         sclk_q <= 1'b0;
      end else if (restart_i) begin
         ph_q   <= '0;
         sclk_q <= 1'b0;
      end else if (run_i) begin
         if (phase_end) begin
            ph_q   <= '0;
            sclk_q <= ~sclk_q;
         end else begin
            ph_q   <= ph_q + 1'b1;
         end
      end
   end

   AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !restart_i && ph_q != phase_lim) |=> $stable(sclk_q)); // R5

   AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> !sclk_q); // R4

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
   import cfg_loader_pkg::*;
#(
   parameter int CLK_MHZ     = 50,
   parameter int US_W        = 16,
   parameter int CNT_W       = 8,
   parameter int HALF_W      = 8,
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              slow_mode_i,
   input  logic [US_W-1:0]   hold_us_i,
   input  logic [US_W-1:0]   wait_us_i,
   input  logic [CNT_W-1:0]  lead_clks_i,
   input  logic [CNT_W-1:0]  trail_clks_i,
   input  logic [HALF_W-1:0] half_period_i,
   input  logic [BYTE_W-1:0] s_data_i,
   input  logic              s_valid_i,
   input  logic              s_last_i,
   output logic              s_ready_o,
   output logic              cfg_rst_no,
   output logic              cfg_cs_no,
   output logic              cfg_sclk_o,
   output logic              cfg_copi_o,
   input  logic              cfg_done_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              error_o
);
   localparam int BC_W = $clog2(BYTE_W + 1);

   // elaboration-time parameter checks
   if (CLK_MHZ < 1) begin : g_bad_clk
      $error("cfg_loader: CLK_MHZ must be at least 1");
   end
   if (BYTE_W < 2) begin : g_bad_byte
      $error("cfg_loader: BYTE_W must be at least 2");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("cfg_loader: SYNC_STAGES must be 0 to 4");
   end

   ld_state_e         state_q, state_d;
   logic [CNT_W-1:0]  clk_cnt_q;
   logic [BYTE_W-1:0] shreg_q;
   logic [BC_W-1:0]   bits_q;
   logic              last_q, done_q, err_q;
   logic              done_s, tmr_exp, tmr_en, sclk_fall, sclk_run, restart;
   logic              accept, lead_left, trail_left, bits_empty;
   logic [US_W-1:0]   tmr_limit;

   // configuration-done synchronizer, depth chosen by parameter
   if (SYNC_STAGES == 0) begin : g_nosync
      assign done_s = cfg_done_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) sync_q <= '0;
         else         sync_q <= (sync_q << 1) | SYNC_STAGES'(cfg_done_i);
      end
      assign done_s = sync_q[SYNC_STAGES-1];
   end

   assign bits_empty = (bits_q == '0);
   assign lead_left  = clk_cnt_q < lead_clks_i;
   assign trail_left = clk_cnt_q < trail_clks_i;
   assign s_ready_o  = (state_q == ST_LOAD) && bits_empty && !last_q;
   assign accept     = s_ready_o && s_valid_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start_i)               state_d = ST_RESET;
         ST_RESET: if (tmr_exp)               state_d = ST_CLEAR;
         ST_CLEAR: if (tmr_exp)               state_d = ST_PRE;
         ST_PRE:   if (!lead_left)            state_d = ST_LOAD;
         ST_LOAD:  if (bits_empty && last_q)  state_d = ST_POST;
         ST_POST:  if (!trail_left)           state_d = ST_IDLE;
         default:                             state_d = ST_IDLE;
      endcase
   end

   assign restart   = (state_d != state_q);
   assign tmr_en    = (state_q == ST_RESET) || (state_q == ST_CLEAR);
   assign tmr_limit = (state_q == ST_CLEAR) ? wait_us_i : hold_us_i;
   assign sclk_run  = ((state_q == ST_PRE)  && lead_left)  ||
                      ((state_q == ST_POST) && trail_left) ||
                      ((state_q == ST_LOAD) && !bits_empty);

   cfg_us_timer #(.CLK_MHZ(CLK_MHZ), .US_W(US_W)) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (tmr_en),
      .clr_i     (restart),
      .limit_i   (tmr_limit),
      .expired_o (tmr_exp)
   );

   cfg_sclk_gen #(.HALF_W(HALF_W)) u_sclk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (sclk_run),
      .restart_i (restart),
      .slow_i    (slow_mode_i),
      .half_i    (half_period_i),
      .sclk_o    (cfg_sclk_o),
      .fall_o    (sclk_fall)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= ST_IDLE;
         clk_cnt_q <= '0;
         shreg_q   <= '0;
         bits_q    <= '0;
         last_q    <= 1'b0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         if (restart)
            clk_cnt_q <= '0;
         else if (sclk_fall && (state_q == ST_PRE || state_q == ST_POST))
            clk_cnt_q <= clk_cnt_q + 1'b1;
         if (accept) begin
            shreg_q <= s_data_i;
            bits_q  <= BC_W'(BYTE_W);
            last_q  <= s_last_i;
         end else if (sclk_fall && state_q == ST_LOAD) begin
            shreg_q <= shreg_q << 1;
            bits_q  <= bits_q - 1'b1;
         end
         if (state_q == ST_IDLE && start_i) begin
            last_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
         end else if (state_q == ST_POST && !trail_left) begin
            done_q <= done_s;
            err_q  <= !done_s;
         end
      end
   end

   assign cfg_rst_no = (state_q != ST_RESET);
   assign cfg_cs_no  = (state_q != ST_LOAD);
   assign cfg_copi_o = shreg_q[BYTE_W-1];
   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = done_q;
   assign error_o    = err_q;

   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> (!cfg_sclk_o && cfg_cs_no && cfg_rst_no && !s_ready_o)); // R1

   AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_rst_no |-> (cfg_cs_no && !cfg_sclk_o)); // R2

   AST_NO_REPEAT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && cfg_rst_no) |=> cfg_rst_no); // R10

   AST_COPI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_sclk_o |=> (!cfg_sclk_o || $stable(cfg_copi_o))); // R6

   AST_READY_IN_PAYLOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s_ready_o |-> (!cfg_cs_no && !cfg_sclk_o)); // R7

   AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(done_o && error_o)); // R9

   AST_FLAGS_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> (!done_o && !error_o)); // R9

endmodule

// File: tb/cfg_loader_tb_top.sv
module cfg_loader_tb_top;
   localparam int MHZ = 50;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       slow_mode = 1'b0;
   logic [15:0] hold_us = '0, wait_us = '0;
   logic [7:0] lead_clks = '0, trail_clks = '0, half_period = '0;
   logic [7:0] s_data = '0;
   logic       s_valid = 1'b0, s_last = 1'b0;
   logic       s_ready, cfg_rst_n, cfg_cs_n, cfg_sclk, cfg_copi, busy, done_f, err_f;
   logic       cfg_done = 1'b0;

   always #10 clk = ~clk;

   cfg_loader dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .slow_mode_i(slow_mode),
      .hold_us_i(hold_us), .wait_us_i(wait_us), .lead_clks_i(lead_clks),
      .trail_clks_i(trail_clks), .half_period_i(half_period),
      .s_data_i(s_data), .s_valid_i(s_valid), .s_last_i(s_last), .s_ready_o(s_ready),
      .cfg_rst_no(cfg_rst_n), .cfg_cs_no(cfg_cs_n), .cfg_sclk_o(cfg_sclk),
      .cfg_copi_o(cfg_copi), .cfg_done_i(cfg_done), .busy_o(busy),
      .done_o(done_f), .error_o(err_f)
   );

   int n_checks = 0, n_fail = 0;
   bit finished = 0;

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- reference model expectations ----------------
   logic e_rst_n = 1, e_cs_n = 1, e_sclk = 0, e_copi = 0, e_ready = 0;
   logic e_busy = 0, e_done = 0, e_err = 0;
   bit   cmp_en = 0;

   // run statistics gathered at the ports
   int rst_low, rise_hi, rise_lo, clr_cnt;
   bit seen_hi, prev_sclk;

   always @(negedge clk) begin
      if (cmp_en) begin
         check(cfg_rst_n == e_rst_n, "R2", "cfg reset", cfg_rst_n, e_rst_n);
         check(cfg_cs_n  == e_cs_n,  "R6", "chip select", cfg_cs_n, e_cs_n);
         check(cfg_sclk  == e_sclk,  "R5", "serial clock", cfg_sclk, e_sclk);
         check(cfg_copi  == e_copi,  "R6", "serial data", cfg_copi, e_copi);
         check(s_ready   == e_ready, "R7", "ready", s_ready, e_ready);
         check(busy      == e_busy,  "R9", "busy", busy, e_busy);
         check(done_f    == e_done,  "R9", "done", done_f, e_done);
         check(err_f     == e_err,   "R9", "error", err_f, e_err);
      end
      if (busy) begin
         if (!cfg_rst_n) rst_low++;
         if (cfg_sclk && !prev_sclk) begin
            if (cfg_cs_n) rise_hi++;
            else          rise_lo++;
         end
         if (cfg_sclk) seen_hi = 1;
         else if (cfg_rst_n && !seen_hi) clr_cnt++;
      end
      prev_sclk = cfg_sclk;
   end

   task automatic hold(int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   function automatic int atleast1(int v);
      return (v < 1) ? 1 : v;
   endfunction

   task automatic burst(int t, int l);
      for (int i = 0; i < t; i++) begin
         e_sclk = 0; hold(l);
         e_sclk = 1; hold(l);
      end
      e_sclk = 0;
   endtask

   // behavioural model of one run, entered just after the start edge
   task automatic model_run(int h, int w, int pre, int post, int l, bit ok);
      bit got_last = 0;
      bit acc, lst;
      logic [7:0] d;
      e_busy = 1; e_done = 0; e_err = 0; e_rst_n = 0; e_cs_n = 1;
      e_sclk = 0; e_copi = 0; e_ready = 0;
      hold(atleast1(h) * MHZ);
      e_rst_n = 1;
      hold(atleast1(w) * MHZ);
      burst(pre, l);
      hold(1);
      e_cs_n = 0; e_ready = 1;
      while (!got_last) begin
         @(negedge clk); #2;
         acc = s_valid; d = s_data; lst = s_last;
         @(posedge clk); #1;
         if (acc) begin
            e_ready = 0;
            for (int b = 7; b >= 0; b--) begin
               e_copi = d[b];
               e_sclk = 0; hold(l);
               e_sclk = 1; hold(l);
            end
            e_copi = 0; e_sclk = 0;
            got_last = lst;
            if (!lst) e_ready = 1;
         end
      end
      hold(1);
      e_cs_n = 1;
      burst(post, l);
      hold(1);
      e_busy = 0;
      if (ok) e_done = 1;
      else    e_err = 1;
   endtask

   logic [7:0] tx_d[4];
   int         tx_gap[4];
   int         tx_n;

   task automatic drive_bytes(bit mid_start);
      bit r;
      for (int i = 0; i < tx_n; i++) begin
         repeat (tx_gap[i]) @(negedge clk);
         #1;
         s_valid = 1; s_data = tx_d[i]; s_last = (i == tx_n - 1);
         forever begin
            r = s_ready;
            @(posedge clk);
            if (r) break;
            @(negedge clk); #1;
         end
         @(negedge clk); #1;
         s_valid = 0; s_last = 0; s_data = 8'h00;
         if (mid_start && i == 0) begin
            start_i = 1;
            @(negedge clk); #1;
            start_i = 0;
            @(negedge clk);
            // R10: a start while busy must not restart the sequence
            check(busy == 1 && cfg_rst_n == 1, "R10", "start ignored while busy",
                  {cfg_rst_n, busy}, 3);
         end
      end
   endtask

   task automatic do_run(int h, int w, int pre, int post, bit slow, int half,
                         bit ok, bit mid_start, string tag);
      int l;
      l = slow ? half + 1 : 1;
      hold_us = 16'(h); wait_us = 16'(w); lead_clks = 8'(pre); trail_clks = 8'(post);
      slow_mode = slow; half_period = 8'(half); cfg_done = ok;
      repeat (4) @(negedge clk);
      rst_low = 0; rise_hi = 0; rise_lo = 0; clr_cnt = 0; seen_hi = 0;
      #1 start_i = 1;
      fork
         begin
            @(posedge clk); #1;
            model_run(h, w, pre, post, l, ok);
         end
         begin
            @(negedge clk); #1;
            start_i = 0;
            drive_bytes(mid_start);
         end
      join
      @(negedge clk);
      // R2 / R11: reset low time, zero served as one microsecond
      check(rst_low == atleast1(h) * MHZ, (h == 0) ? "R11" : "R2",
            {tag, " reset low cycles"}, rst_low, atleast1(h) * MHZ);
      // R4 and R8: dummy clock pulses with chip select high
      check(rise_hi == pre + post, (pre == 0) ? "R11" : "R4",
            {tag, " leading+trailing pulses"}, rise_hi, pre + post);
      check(rise_lo == 8 * tx_n, "R6", {tag, " payload pulses"}, rise_lo, 8 * tx_n);
      if (pre > 0)
         check(clr_cnt == atleast1(w) * MHZ + l, "R3", {tag, " clear wait cycles"},
               clr_cnt, atleast1(w) * MHZ + l);
      check(done_f == ok && err_f == !ok, "R9", {tag, " outcome flags"},
            {done_f, err_f}, {ok, !ok});
      repeat (3) @(negedge clk);
      check(done_f == ok && busy == 0, "R9", {tag, " flag persists"}, {done_f, busy}, {ok, 1'b0});
      check(cfg_sclk == 0 && cfg_cs_n == 1 && cfg_rst_n == 1, "R8",
            {tag, " quiet after trailing clocks"}, {cfg_sclk, cfg_cs_n, cfg_rst_n}, 3);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: outputs after reset
      check(cfg_sclk == 0, "R1", "idle sclk", cfg_sclk, 0);
      check(cfg_cs_n == 1, "R1", "idle chip select", cfg_cs_n, 1);
      check(cfg_rst_n == 1, "R1", "idle cfg reset", cfg_rst_n, 1);
      check(s_ready == 0 && busy == 0, "R1", "idle ready/busy", {s_ready, busy}, 0);
      cmp_en = 1;

      // fast mode, two bytes with a gap, mid-run start pulse (R10)
      tx_n = 2; tx_d[0] = 8'hA5; tx_d[1] = 8'h3C; tx_gap[0] = 0; tx_gap[1] = 3;
      do_run(1, 2, 3, 4, 0, 0, 1, 1, "fast");

      // slow mode, three bytes, done low gives error (R5, R9)
      tx_n = 3; tx_d[0] = 8'h81; tx_d[1] = 8'h7E; tx_d[2] = 8'hC3;
      tx_gap[0] = 2; tx_gap[1] = 0; tx_gap[2] = 5;
      do_run(2, 1, 2, 5, 1, 2, 0, 0, "slow");

      // all zero settings (R11), also clears the previous error flag (R9)
      tx_n = 1; tx_d[0] = 8'h5A; tx_gap[0] = 1;
      do_run(0, 0, 0, 0, 0, 0, 1, 0, "zero");

      // 1 MHz bit rate at 50 MHz, 8 leading and 49 trailing clocks
      tx_n = 1; tx_d[0] = 8'hF0; tx_gap[0] = 0;
      do_run(1, 1, 8, 49, 1, 24, 1, 0, "1mhz");

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule